// File: doc/BRIEF.md
# OFDM Symbol Double-Bank Buffer

This block sits between a subcarrier mapper and a pipelined transform engine in an OFDM transmit path. The mapper delivers one complex data sample per clock. The block stores each sample in one of two symbol banks. The transform side receives a full 512-point frame in natural carrier order, one point per clock. While one bank is being filled with the current symbol, the other bank is read out, and it holds the symbol filled in the previous period.

Frame timing drives a single-cycle symbol-start strobe. That strobe is the only event that swaps the banks, restarts the fill pointer and starts a new readout. Only the 480 data samples are stored. During readout, 20 pilots with a fixed alternating sign are inserted at evenly spaced positions among the 500 used carriers. DC and the guard carriers around the frame midpoint read as zero. If a strobe arrives before the mapper has delivered a whole symbol, a one-cycle overrun pulse is raised.

Top module: `ofdm_symbol_pingpong`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `overrun` are 0 and `fill_bank` is 0.
- R2: `fill_bank` inverts on every clock edge at which `sym_start` is high and holds at every other edge. Samples are written into the bank that `fill_bank` names, and a sample accepted in the strobe cycle goes into the newly selected bank.
- R3: The k-th sample accepted with `in_valid` since the last strobe (k counted from 0, the strobe-cycle sample included) becomes data carrier k. Samples after the 480th in one period are ignored.
- R4: If `sym_start` is sampled high in cycle c, then during cycle c+2+n `out_valid` is 1 and `out_idx` is n, for n = 0..511. After that `out_valid` is 0 until the next strobe. The data read comes from the bank filled in the period before that strobe.
- R5: Indices 0 and 251..261 are empty carriers and read as `out_data` = 0.
- R6: For any other index, the used position p is idx-1 when idx ≤ 250 and idx-12 when idx ≥ 262. A carrier with p mod 25 = 12 is pilot number p/25. Its `out_data` is {I,Q}, with I in the upper 12 bits and Q = 0. I is +1024 for an even pilot number and -1024 for an odd one.
- R7: The remaining 480 used carriers, taken in increasing index order, carry data carriers 0..479 of the previous symbol.
- R8: `overrun` is high in cycle c+1, for one cycle only, when `sym_start` is high in cycle c and fewer than 480 samples were accepted since the previous strobe. It never fires on the first strobe after reset.
- R9: Data slots not written during a period keep the contents that bank held before.
- R10: A strobe that arrives during a readout restarts the readout, and index 0 appears two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_start | input | 1 | Symbol-period start strobe from frame timing |
| in_valid | input | 1 | Mapper sample valid |
| in_data | input | 24 | Mapper sample {I,Q} |
| fill_bank | output | 1 | Bank currently being filled |
| out_valid | output | 1 | Readout sample valid |
| out_idx | output | 9 | Carrier index of the readout sample |
| out_data | output | 24 | Readout sample {I,Q} |
| overrun | output | 1 | Symbol incomplete at strobe, one-cycle pulse |

## Verification
Two events can land in the same cycle: the symbol-start strobe and an incoming mapper sample. On that edge the bank swaps, the fill pointer restarts, the overrun decision is taken and the sample is stored. The bench drives sample 0 of every symbol in the strobe cycle itself. It then judges at the next readout that this sample surfaces as data carrier 0 of the new symbol and is not counted toward the old one. The bench also checks that the overrun pulse reflects only the samples accepted before the strobe.

// File: rtl/ofdm_symbol_pingpong.sv
module ofdm_symbol_pingpong #(
  parameter int W         = 12,
  parameter int NFFT      = 512,
  parameter int NDATA     = 480,
  parameter int NPILOT    = 20,
  parameter int PILOT_AMP = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sym_start,
  input  logic                     in_valid,
  input  logic [2*W-1:0]           in_data,
  output logic                     fill_bank,
  output logic                     out_valid,
  output logic [$clog2(NFFT)-1:0]  out_idx,
  output logic [2*W-1:0]           out_data,
  output logic                     overrun
);
  localparam int IDXW  = $clog2(NFFT);
  localparam int DW    = $clog2(NDATA + 1);
  localparam int NUSED = NDATA + NPILOT;
  localparam int HALF  = NUSED / 2;
  localparam int GROUP = NUSED / NPILOT;
  localparam int PSLOT = GROUP / 2;
  localparam int GW    = $clog2(GROUP);
  localparam int PW    = $clog2(NPILOT + 1);
  localparam logic [W-1:0] PPOS = W'(PILOT_AMP);
  localparam logic [W-1:0] PNEG = W'(-PILOT_AMP);

  logic [2*W-1:0] mem [2][NDATA];

  logic [DW-1:0]   wr_cnt;
  logic            primed;
  logic            rd_active;
  logic [IDXW-1:0] rd_idx;
  logic [GW-1:0]   gslot;
  logic [PW-1:0]   pcnt;
  logic [DW-1:0]   dptr;

  wire            wr_bank = sym_start ? ~fill_bank : fill_bank;
  wire [DW-1:0]   wr_ptr  = sym_start ? '0 : wr_cnt;
  wire            do_wr   = in_valid && (wr_ptr < DW'(NDATA));
  wire            rd_bank = ~fill_bank;
  wire            is_zero = (rd_idx == '0) ||
                            ((rd_idx > IDXW'(HALF)) && (rd_idx < IDXW'(NFFT - HALF)));
  wire            is_pilot = !is_zero && (gslot == GW'(PSLOT));
  wire [W-1:0]    pilot_i  = pcnt[0] ? PNEG : PPOS;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_bank][wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_bank <= 1'b0;
      wr_cnt    <= '0;
      primed    <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      fill_bank <= fill_bank ^ sym_start;
      primed    <= primed | sym_start;
      overrun   <= sym_start && primed && (wr_cnt < DW'(NDATA));
      if (do_wr)          wr_cnt <= wr_ptr + 1'b1;
      else if (sym_start) wr_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_idx    <= '0;
      gslot     <= '0;
      pcnt      <= '0;
      dptr      <= '0;
    end else if (sym_start) begin
      rd_active <= 1'b1;
      rd_idx    <= '0;
      gslot     <= '0;
      pcnt      <= '0;
      dptr      <= '0;
    end else if (rd_active) begin
      rd_idx <= rd_idx + 1'b1;
      if (rd_idx == IDXW'(NFFT - 1)) rd_active <= 1'b0;
      if (!is_zero) begin
        gslot <= (gslot == GW'(GROUP - 1)) ? '0 : gslot + 1'b1;
        if (is_pilot) pcnt <= pcnt + 1'b1;
        else          dptr <= dptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= rd_active;
      out_idx   <= rd_idx;
      if (is_zero)                    out_data <= '0;
      else if (is_pilot)              out_data <= {pilot_i, {W{1'b0}}};
      else if (dptr < DW'(NDATA))     out_data <= mem[rd_bank][dptr];
      else                            out_data <= '0;
    end
  end
endmodule

// File: rtl/ofdm_symbol_pingpong_chk.sv
module ofdm_symbol_pingpong_chk #(
  parameter int IDXW = 9,
  parameter int DATW = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sym_start,
  input logic            fill_bank,
  input logic            out_valid,
  input logic [IDXW-1:0] out_idx,
  input logic [DATW-1:0] out_data,
  input logic            overrun
);
  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_start |=> $stable(fill_bank));
  // R2
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start |=> (fill_bank != $past(fill_bank)));
  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(sym_start));
  // R8
  overrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && !$past(sym_start, 2)) |-> (out_idx == $past(out_idx) + 1'b1));
  // R5
  dc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx == '0) |-> (out_data == '0));
endmodule

bind ofdm_symbol_pingpong ofdm_symbol_pingpong_chk #(.IDXW($clog2(NFFT)), .DATW(2*W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_start(sym_start), .fill_bank(fill_bank),
  .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data), .overrun(overrun));

// File: tb/tb_ofdm_symbol_pingpong.sv
module tb_ofdm_symbol_pingpong;
  localparam int P    = 600;
  localparam int NENT = 9;
  // {gap, offered samples}
  localparam logic [11:0] TBL [NENT] = '{
    {1'b0, 11'd480}, {1'b1, 11'd480}, {1'b0, 11'd300}, {1'b0, 11'd500},
    {1'b1, 11'd479}, {1'b0, 11'd480}, {1'b0, 11'd0},   {1'b0, 11'd480},
    {1'b0, 11'd480}};

  logic clk = 1'b0, rst_n = 1'b0, sym_start = 1'b0, in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic fill_bank, out_valid, overrun;
  logic [8:0] out_idx;
  logic [23:0] out_data;

  ofdm_symbol_pingpong dut (.clk(clk), .rst_n(rst_n), .sym_start(sym_start),
    .in_valid(in_valid), .in_data(in_data), .fill_bank(fill_bank),
    .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data), .overrun(overrun));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [23:0] bank_m [2][480];
  int src [2][480];

  function automatic logic [23:0] gen(int s, int j);
    return {12'((s * 37 + j * 3) & 12'hfff), 12'((j ^ (s << 7)) & 12'hfff)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_sample(int idx, int k);
    int p;
    logic [23:0] e;
    string tag;
    bit skip;
    chk(out_valid && out_idx == 9'(idx), "R4", {22'd0, out_valid, out_idx}, {22'd0, 1'b1, 9'(idx)});
    skip = 1'b0;
    if (idx == 0 || (idx >= 251 && idx <= 261)) begin
      e = '0; tag = "R5";
    end else begin
      p = (idx <= 250) ? idx - 1 : idx - 12;
      if (p % 25 == 12) begin
        e = {((p / 25) % 2 == 0) ? 12'd1024 : 12'hc00, 12'd0}; tag = "R6";
      end else begin
        int d;
        d = p - p / 25 - ((p % 25 > 12) ? 1 : 0);
        e = bank_m[k % 2][d];
        if (src[k % 2][d] < 0) skip = 1'b1;
        else if (src[k % 2][d] != k - 1) tag = "R9";
        else if (TBL[k - 1][10:0] > 480) tag = "R3";
        else tag = "R7";
      end
    end
    if (!skip) chk(out_data == e, tag, {8'd0, out_data}, {8'd0, e});
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 480; i++) src[b][i] = -1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !overrun && !fill_bank, "R1", {29'd0, out_valid, overrun, fill_bank}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !overrun && !fill_bank, "R1", {29'd0, out_valid, overrun, fill_bank}, 32'd0);
    for (int k = 0; k < NENT; k++) begin
      int wc;
      wc = 0;
      for (int t = 0; t < P; t++) begin
        if (t > 0) @(negedge clk);
        if (t == 1) begin
          chk(overrun == (k >= 1 && TBL[k == 0 ? 0 : k - 1][10:0] < 480), "R8",
              {31'd0, overrun}, {31'd0, (k >= 1 && TBL[k == 0 ? 0 : k - 1][10:0] < 480)});
          chk(fill_bank == 1'((k + 1) % 2), "R2", {31'd0, fill_bank}, 32'((k + 1) % 2));
          chk(!out_valid, "R4", {31'd0, out_valid}, 32'd0);
        end
        if (t == 2) chk(!overrun, "R8", {31'd0, overrun}, 32'd0);
        if (t >= 2 && t <= 513) check_sample(t - 2, k);
        if (t == 300) chk(fill_bank == 1'((k + 1) % 2), "R2", {31'd0, fill_bank}, 32'((k + 1) % 2));
        if (t == 514 || t == P - 1) chk(!out_valid, "R4", {31'd0, out_valid}, 32'd0);
        sym_start = (t == 0);
        in_valid  = (wc < int'(TBL[k][10:0])) && !(TBL[k][11] && (t % 8 == 7));
        in_data   = gen(k, wc);
        if (in_valid) begin
          if (wc < 480) begin
            bank_m[(k + 1) % 2][wc] = gen(k, wc);
            src[(k + 1) % 2][wc] = k;
          end
          wc++;
        end
      end
      @(negedge clk);
      sym_start = 1'b0; in_valid = 1'b0;
    end
    // R10: restart during readout
    sym_start = 1'b1;
    @(negedge clk);
    sym_start = 1'b0;
    repeat (99) @(negedge clk);
    sym_start = 1'b1;
    @(negedge clk);
    sym_start = 1'b0;
    chk(overrun, "R8", {31'd0, overrun}, 32'd1);
    @(negedge clk);
    chk(out_valid && out_idx == 9'd0, "R10", {22'd0, out_valid, out_idx}, {22'd0, 1'b1, 9'd0});
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && !overrun && !fill_bank, "R1", {29'd0, out_valid, overrun, fill_bank}, 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule